// File: doc/BRIEF.md
# Program Counter and Call Stack

This block holds the 10-bit fetch address of a small 8-bit controller and a five-entry circular return stack. Each cycle it receives one decoded operation on `op_i`, together with a 10-bit branch target and an 8-bit data byte, and it picks the next fetch address. The operations are a plain advance, an absolute jump, a subroutine call, a return, an interrupt entry, a direct write of the data byte into the PC, and an addition of the data byte to the PC. The decoder sits upstream, and the data byte comes from the accumulator or from the ALU result.

Any operation that redirects the PC costs one more instruction cycle. In the cycle after a redirect the block raises `stall_o`, keeps the PC where it is and ignores whatever is on `op_i`. Writes that treat the PC as a data register (load and add) put their result in the low byte and force the two top bits to zero. Computed branches can therefore only land in the first 256 words.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is 000H and `stall_o` is 0. Reset also clears every stack entry, so a return issued right after reset yields 000H.
- R2: Outside a stall, `op_i`=0 (advance), or the spare code 7 which behaves the same, sets `pc_o` to `pc_o`+1, wrapping from 3FFH to 000H. No stall follows.
- R3: Outside a stall, `op_i`=1 (jump) loads all 10 bits of `target_i` into `pc_o`.
- R4: Outside a stall, `op_i`=2 (call) loads `target_i` into `pc_o` and pushes `pc_o`+1 onto the stack.
- R5: Outside a stall, `op_i`=3 (return) loads `pc_o` from the most recent stack entry and pops it. Nested calls unwind in last-in, first-out order.
- R6: Outside a stall, `op_i`=4 (interrupt entry) pushes `pc_o`+1 and loads 008H.
- R7: Outside a stall, `op_i`=5 (register write) sets `pc_o` to `data_i` in bits 7..0 and to zero in bits 9..8.
- R8: Outside a stall, `op_i`=6 (register add) sets bits 7..0 of `pc_o` to the 8-bit sum of `pc_o[7:0]` and `data_i`, drops the carry, and clears bits 9..8.
- R9: Op codes 1 to 6 raise `stall_o` for exactly the next cycle. Codes 0 and 7 leave it low.
- R10: While `stall_o` is high, `op_i` has no effect: `pc_o` holds and the stack is neither pushed nor popped.
- R11: The stack is circular with five entries. A sixth push overwrites the oldest entry. Popping more entries than were pushed returns the entry selected by the wrapped pointer, and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Decoded operation code (see requirements) |
| target_i | input | 10 | Absolute address for jump and call |
| data_i | input | 8 | Byte for register write or add |
| pc_o | output | 10 | Current fetch address |
| stall_o | output | 1 | Extra-cycle request following a redirect |

## Verification
A corrupted stack pointer or entry shows up at `pc_o` one cycle after the next return. The bench therefore nests calls and interrupts, unwinds them, and drives the pointer past both ends of the stack. A wrong stall register appears at once: either `stall_o` is wrong in the cycle after a redirect, or `pc_o` moves during a cycle that should hold. Hostile operations placed in stall cycles expose any missing gating of pushes and pops, which surfaces on the following returns.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    OP_STEP  = 3'd0,
    OP_JUMP  = 3'd1,
    OP_CALL  = 3'd2,
    OP_RET   = 3'd3,
    OP_IRQ   = 3'd4,
    OP_LOADW = 3'd5,
    OP_ADDW  = 3'd6,
    OP_SPARE = 3'd7
  } pc_op_e;
endpackage

// File: rtl/pcseq_ret_stack.sv
module pcseq_ret_stack #(
  parameter int W     = 10,
  parameter int DEPTH = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] top_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q, ptr_inc, ptr_dec;
  logic [W-1:0]     mem [DEPTH];

  assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  assign ptr_dec = (ptr_q == '0) ? LAST : ptr_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (push_i) ptr_q <= ptr_inc;
    else if (pop_i)  ptr_q <= ptr_dec;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic [W-1:0] entry_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                entry_q <= '0;
      else if (push_i && ptr_q == PTR_W'(i))      entry_q <= push_data_i;
    end
    assign mem[i] = entry_q;
  end

  // wrapped read: empty pop yields whatever the pointer selects
  assign top_o = mem[ptr_dec];
endmodule

// File: rtl/pcseq_next_addr.sv
module pcseq_next_addr
  import pcseq_pkg::*;
#(
  parameter int PC_W    = 10,
  parameter int DATA_W  = 8,
  parameter logic [PC_W-1:0] IRQ_VEC = 10'h008
) (
  input  logic [PC_W-1:0]   pc_i,
  input  pc_op_e            op_i,
  input  logic              hold_i,
  input  logic [PC_W-1:0]   target_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [PC_W-1:0]   top_i,
  output logic [PC_W-1:0]   pc_next_o,
  output logic              push_o,
  output logic              pop_o,
  output logic [PC_W-1:0]   push_data_o,
  output logic              redirect_o
);
  logic [PC_W-1:0]   pc_inc;
  logic [DATA_W-1:0] low_sum;

  assign pc_inc      = pc_i + 1'b1;
  assign low_sum     = pc_i[DATA_W-1:0] + data_i;
  assign push_data_o = pc_inc;

  always_comb begin
    pc_next_o  = pc_inc;
    push_o     = 1'b0;
    pop_o      = 1'b0;
    redirect_o = 1'b1;
    if (hold_i) begin
      pc_next_o  = pc_i;
      redirect_o = 1'b0;
    end else begin
      unique case (op_i)
        OP_JUMP:  pc_next_o = target_i;
        OP_CALL: begin
          pc_next_o = target_i;
          push_o    = 1'b1;
        end
        OP_RET: begin
          pc_next_o = top_i;
          pop_o     = 1'b1;
        end
        OP_IRQ: begin
          pc_next_o = IRQ_VEC;
          push_o    = 1'b1;
        end
        // register-style writes clear the upper PC bits
        OP_LOADW: pc_next_o = PC_W'(data_i);
        OP_ADDW:  pc_next_o = PC_W'(low_sum);
        default:  redirect_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pcseq_stall_ctrl.sv
module pcseq_stall_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic redirect_i,
  output logic stall_o
);
  logic stall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_q <= 1'b0;
    else         stall_q <= redirect_i;
  end

  assign stall_o = stall_q;
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int PC_W        = 10,
  parameter int DATA_W      = 8,
  parameter int STACK_DEPTH = 5,
  parameter logic [PC_W-1:0] RESET_VEC = 10'h000,
  parameter logic [PC_W-1:0] IRQ_VEC   = 10'h008
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic [PC_W-1:0]   target_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              stall_o
);
  logic [PC_W-1:0] pc_q, pc_next, push_data, top;
  logic            push, pop, redirect, hold;

  pcseq_next_addr #(
    .PC_W(PC_W), .DATA_W(DATA_W), .IRQ_VEC(IRQ_VEC)
  ) i_next_addr (
    .pc_i       (pc_q),
    .op_i       (pc_op_e'(op_i)),
    .hold_i     (hold),
    .target_i   (target_i),
    .data_i     (data_i),
    .top_i      (top),
    .pc_next_o  (pc_next),
    .push_o     (push),
    .pop_o      (pop),
    .push_data_o(push_data),
    .redirect_o (redirect)
  );

  pcseq_ret_stack #(.W(PC_W), .DEPTH(STACK_DEPTH)) i_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .pop_i      (pop),
    .push_data_i(push_data),
    .top_o      (top)
  );

  pcseq_stall_ctrl i_stall (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .redirect_i(redirect),
    .stall_o   (hold)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_VEC;
    else         pc_q <= pc_next;
  end

  assign pc_o    = pc_q;
  assign stall_o = hold;
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker
  import pcseq_pkg::*;
#(
  parameter int PC_W   = 10,
  parameter int DATA_W = 8,
  parameter logic [PC_W-1:0] IRQ_VEC = 10'h008
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        op_i,
  input logic [PC_W-1:0]   target_i,
  input logic [DATA_W-1:0] data_i,
  input logic [PC_W-1:0]   pc_o,
  input logic              stall_o
);
  logic is_step, is_redirect;
  assign is_step     = (op_i == OP_STEP) || (op_i == OP_SPARE);
  assign is_redirect = !is_step;

  a_r2_step_increments: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && is_step) |=> (pc_o == PC_W'($past(pc_o) + 1'b1)) && !stall_o);

  a_r3_jump_loads_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && op_i == OP_JUMP) |=> pc_o == $past(target_i));

  a_r6_irq_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && op_i == OP_IRQ) |=> pc_o == IRQ_VEC);

  a_r7_load_low_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && op_i == OP_LOADW) |=> pc_o == PC_W'($past(data_i)));

  // covers R8 too: computed writes stay in the first 256 words
  a_r7_high_bits_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && (op_i == OP_LOADW || op_i == OP_ADDW)) |=> pc_o[PC_W-1:DATA_W] == '0);

  a_r9_stall_after_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && is_redirect) |=> stall_o);

  a_r10_hold_in_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(pc_o) && !stall_o);
endmodule

bind pc_sequencer pcseq_checker #(
  .PC_W(PC_W), .DATA_W(DATA_W), .IRQ_VEC(IRQ_VEC)
) i_pcseq_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .target_i(target_i),
  .data_i(data_i), .pc_o(pc_o), .stall_o(stall_o)
);

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 31;

  // {op[31:29], target[28:19], data[18:11], exp_pc[10:1], exp_stall[0]}
  localparam logic [31:0] VEC [NVEC] = '{
    {3'd0, 10'h000, 8'h00, 10'h001, 1'b0},
    {3'd0, 10'h000, 8'h00, 10'h002, 1'b0},
    {3'd1, 10'h2F0, 8'h00, 10'h2F0, 1'b1},
    {3'd3, 10'h000, 8'h00, 10'h2F0, 1'b0},
    {3'd2, 10'h155, 8'h00, 10'h155, 1'b1},
    {3'd0, 10'h000, 8'h00, 10'h155, 1'b0},
    {3'd0, 10'h000, 8'h00, 10'h156, 1'b0},
    {3'd2, 10'h0A0, 8'h00, 10'h0A0, 1'b1},
    {3'd4, 10'h000, 8'h00, 10'h0A0, 1'b0},
    {3'd4, 10'h000, 8'h00, 10'h008, 1'b1},
    {3'd0, 10'h000, 8'h00, 10'h008, 1'b0},
    {3'd3, 10'h000, 8'h00, 10'h0A1, 1'b1},
    {3'd0, 10'h000, 8'h00, 10'h0A1, 1'b0},
    {3'd3, 10'h000, 8'h00, 10'h157, 1'b1},
    {3'd0, 10'h000, 8'h00, 10'h157, 1'b0},
    {3'd5, 10'h000, 8'hC3, 10'h0C3, 1'b1},
    {3'd0, 10'h000, 8'h00, 10'h0C3, 1'b0},
    {3'd1, 10'h3F0, 8'h00, 10'h3F0, 1'b1},
    {3'd0, 10'h000, 8'h00, 10'h3F0, 1'b0},
    {3'd6, 10'h000, 8'h20, 10'h010, 1'b1},
    {3'd0, 10'h000, 8'h00, 10'h010, 1'b0},
    {3'd1, 10'h2FE, 8'h00, 10'h2FE, 1'b1},
    {3'd0, 10'h000, 8'h00, 10'h2FE, 1'b0},
    {3'd6, 10'h000, 8'h01, 10'h0FF, 1'b1},
    {3'd0, 10'h000, 8'h00, 10'h0FF, 1'b0},
    {3'd3, 10'h000, 8'h00, 10'h2F1, 1'b1},
    {3'd7, 10'h000, 8'h00, 10'h2F1, 1'b0},
    {3'd1, 10'h3FF, 8'h00, 10'h3FF, 1'b1},
    {3'd0, 10'h000, 8'h00, 10'h3FF, 1'b0},
    {3'd7, 10'h000, 8'h00, 10'h000, 1'b0},
    {3'd0, 10'h000, 8'h00, 10'h001, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op = 3'd0;
  logic [9:0] tgt = '0;
  logic [7:0] dat = '0;
  logic [9:0] pc;
  logic       stall;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_sequencer i_pc_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .target_i(tgt),
    .data_i(dat), .pc_o(pc), .stall_o(stall)
  );

  task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %03h expected %03h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic apply(logic [2:0] o, logic [9:0] t, logic [7:0] d);
    op = o; tgt = t; dat = d;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    op = 3'd0;
    #1;
    check("R1 pc in reset", pc, 10'h000);
    check("R1 stall in reset", {9'd0, stall}, 10'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic string op_tag(logic [2:0] o);
    case (o)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R2";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic in_stall;
    @(negedge clk);
    do_reset();

    // table walk
    in_stall = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][31:29], VEC[i][28:19], VEC[i][18:11]);
      check(in_stall ? "R10 pc held in stall" : op_tag(VEC[i][31:29]), pc, VEC[i][10:1]);
      check("R9 stall flag", {9'd0, stall}, {9'd0, VEC[i][0]});
      in_stall = VEC[i][0];
    end

    // R1: reset during a stall clears it, stack entries read as zero
    apply(3'd1, 10'h123, 8'h00);
    check("R9 stall before reset", {9'd0, stall}, 10'd1);
    do_reset();
    apply(3'd3, 10'h000, 8'h00);
    check("R1 pop after reset gives 000", pc, 10'h000);
    apply(3'd0, 10'h000, 8'h00);

    // R11: six pushes into five entries, then six pops
    do_reset();
    for (int k = 0; k < 6; k++) begin
      apply(3'd2, 10'((k + 1) * 16), 8'h00);
      check("R4 call target", pc, 10'((k + 1) * 16));
      apply(3'd0, 10'h000, 8'h00);
    end
    for (int k = 0; k < 6; k++) begin
      logic [9:0] exp_ret;
      exp_ret = (k < 5) ? 10'(16 * (5 - k) + 1) : 10'h051;
      apply(3'd3, 10'h000, 8'h00);
      check(k < 5 ? "R11 overwrite keeps newest five" : "R11 wrapped pop", pc, exp_ret);
      apply(3'd0, 10'h000, 8'h00);
    end

    // R10: call during stall must not push; following return shows it
    do_reset();
    apply(3'd2, 10'h200, 8'h00);
    apply(3'd2, 10'h300, 8'h00);
    check("R10 call ignored in stall", pc, 10'h200);
    apply(3'd3, 10'h000, 8'h00);
    check("R5 return after ignored call", pc, 10'h001);
    apply(3'd0, 10'h000, 8'h00);
    apply(3'd3, 10'h000, 8'h00);
    check("R10 no extra entry pushed", pc, 10'h000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule